// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Alarm

This block keeps wall-clock time in a 12-hour BCD format. The time is held in four byte registers: tenths of a second, seconds, minutes and hours. Bit 7 of the hours register is the PM flag. The clock advances once per tenth of a second. That tick is derived from an external mains-frequency pulse line, and a mode input says whether the line runs at 50 Hz or 60 Hz. A second register set with the same layout holds an alarm time. A one-cycle strobe is raised when the running time matches the alarm. The strobe feeds an interrupt controller outside the block.

Software reads and writes the registers through a small synchronous port. To read a consistent time across several bytes, reading the hours byte freezes a snapshot, and reading the tenths byte releases it. To set a consistent time, writing the hours byte halts the clock, and writing the tenths byte sets it running again. An alarm-select input steers writes into the alarm set instead of the clock.

Top module: `tod_clock`

## Requirements
- R1: A tenth-second tick occurs on every 5th synchronized rising edge of `line_i` when `mode_50_i` is 1, and on every 6th when it is 0. Any change of `mode_50_i` restarts the edge count from zero.
- R2: Tenths count 0..9, then carry into seconds. Seconds count BCD 00..59, then carry into minutes. Minutes count BCD 00..59, then carry into hours.
- R3: Hours count in BCD 01..12 in bits 4:0, with bit 7 as PM. 09 steps to 10 and 12 steps to 01. The PM flag inverts on the step from 11 to 12.
- R4: Reading hours while no snapshot is held captures all four clock bytes. Later reads return the captured bytes. A tenths read returns the captured value and then drops the snapshot. The live clock keeps counting throughout.
- R5: A clock write to hours stops the clock, and a clock write to tenths starts it. A stopped clock ignores ticks.
- R6: Hours writes keep only bits 7 and 4:0. A clock hours write whose bits 4:0 equal 12 stores the PM bit inverted. Alarm hours writes store it unchanged.
- R7: While `alarm_sel_i` is 1, writes update the alarm registers and leave the clock registers untouched.
- R8: `alarm_o` pulses for one cycle, on the cycle after an applied tick or after any write. It pulses only if the clock is running and all four clock bytes equal the alarm bytes.
- R9: After reset the clock reads 01:00:00.0, the alarm registers are zero, the clock is stopped, no snapshot is held and `alarm_o` is 0.
- R10: `addr_i` selects the byte: 0 is tenths, 1 is seconds, 2 is minutes and 3 is hours. Read data appears on `rd_data_o` on the cycle after `rd_en_i` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Asynchronous mains-frequency pulse line |
| mode_50_i | input | 1 | 1 selects 50 Hz (divide by 5), 0 selects 60 Hz (divide by 6) |
| alarm_sel_i | input | 1 | 1 routes writes into the alarm registers |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 2 | Byte select: 0 tenths, 1 seconds, 2 minutes, 3 hours |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| alarm_o | output | 1 | One-cycle alarm match strobe |

## Verification
Some properties are checked by the assertions on every cycle:
- A stopped clock holds its value.
- Hours and tenths writes stop and start the clock.
- A tenths step adds one.
- Ticks are never adjacent.
- A held snapshot does not drift.
- Alarm writes never disturb the clock.
- The alarm strobe occurs only while the clock is running.

The carry chain, the hour roll-overs with the PM flip, the divide ratio and its restart on a mode change, and the write-path PM inversion can only be shown by the bench scenarios. The same holds for the snapshot release order and the alarm firing on a tick versus on a write. The bench tracks the line-pulse count itself, so it knows exactly which pulse produces a tick.

// File: rtl/tod_pkg.sv
package tod_pkg;

  typedef struct packed {
    logic [7:0] hour;
    logic [7:0] minute;
    logic [7:0] second;
    logic [7:0] tenth;
  } tod_t;

  typedef enum logic [1:0] {
    F_TENTH = 2'd0,
    F_SEC   = 2'd1,
    F_MIN   = 2'd2,
    F_HOUR  = 2'd3
  } field_e;

  localparam logic [7:0] HOUR_MASK = 8'h9f;
  localparam logic [4:0] HOUR_TWELVE = 5'h12;

  // {carry, next}: wraps to 0 after {top_hi, 9}
  function automatic logic [8:0] bcd_inc(input logic [7:0] v, input logic [3:0] top_hi);
    if (v == {top_hi, 4'h9})   return 9'h100;
    else if (v[3:0] == 4'h9)   return {1'b0, v[7:4] + 4'h1, 4'h0};
    else                       return {1'b0, v[7:4], v[3:0] + 4'h1};
  endfunction

  function automatic logic [7:0] hour_inc(input logic [7:0] h);
    logic       pm;
    logic [4:0] hv;
    pm = h[7];
    hv = h[4:0];
    if (hv == 5'h11) pm = ~pm;
    if (hv == HOUR_TWELVE)    hv = 5'h01;
    else if (hv == 5'h09)     hv = 5'h10;
    else                      hv = hv + 5'd1;
    return {pm, 2'b00, hv};
  endfunction

  function automatic logic [7:0] pick_field(input tod_t t, input field_e f);
    case (f)
      F_TENTH: return t.tenth;
      F_SEC:   return t.second;
      F_MIN:   return t.minute;
      default: return t.hour;
    endcase
  endfunction

endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_50      = 5,
  parameter int DIV_60      = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic mode_50_i,
  output logic tick_o
);

  localparam int DIV_MAX = (DIV_50 > DIV_60) ? DIV_50 : DIV_60;
  localparam int CW      = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_d_q;
  logic                   mode_q;
  logic [CW-1:0]          cnt_q;
  logic [CW-1:0]          div_last;
  logic                   rise;
  logic                   mode_chg;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= line_i;
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end
  endgenerate

  assign rise     = sync_q[SYNC_STAGES-1] & ~line_d_q;
  assign div_last = mode_50_i ? CW'(DIV_50 - 1) : CW'(DIV_60 - 1);
  assign mode_chg = mode_50_i != mode_q;
  assign tick_o   = rise && !mode_chg && (cnt_q == div_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_d_q <= 1'b0;
      mode_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      line_d_q <= sync_q[SYNC_STAGES-1];
      mode_q   <= mode_50_i;
      if (mode_chg)    cnt_q <= '0;
      else if (rise)   cnt_q <= (cnt_q == div_last) ? '0 : cnt_q + 1'b1;
    end
  end

  assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  assert_mode_restart_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> !tick_o);

endmodule

// File: rtl/tod_time.sv
module tod_time
  import tod_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  field_e     wr_field_i,
  input  logic [7:0] wr_data_i,
  output tod_t       time_o,
  output logic       run_o,
  output logic       stepped_o
);

  tod_t       time_q, time_nxt;
  logic       run_q;
  logic [8:0] c_t, c_s, c_m;
  logic [7:0] hour_wr;

  always_comb begin
    time_nxt = time_q;
    c_t = bcd_inc(time_q.tenth, 4'h0);
    c_s = bcd_inc(time_q.second, 4'h5);
    c_m = bcd_inc(time_q.minute, 4'h5);
    time_nxt.tenth = c_t[7:0];
    if (c_t[8]) begin
      time_nxt.second = c_s[7:0];
      if (c_s[8]) begin
        time_nxt.minute = c_m[7:0];
        if (c_m[8]) time_nxt.hour = hour_inc(time_q.hour);
      end
    end
  end

  // caller masks hours; twelve flips PM on clock writes only
  assign hour_wr = (wr_data_i[4:0] == HOUR_TWELVE) ? (wr_data_i ^ 8'h80) : wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= '{hour: 8'h01, minute: 8'h00, second: 8'h00, tenth: 8'h00};
      run_q  <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_field_i)
        F_TENTH: begin time_q.tenth <= wr_data_i; run_q <= 1'b1; end
        F_SEC:   time_q.second <= wr_data_i;
        F_MIN:   time_q.minute <= wr_data_i;
        default: begin time_q.hour <= hour_wr; run_q <= 1'b0; end
      endcase
    end else if (tick_i && run_q) begin
      time_q <= time_nxt;
    end
  end

  assign time_o    = time_q;
  assign run_o     = run_q;
  assign stepped_o = tick_i & run_q & ~wr_en_i;

  assert_stopped_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !wr_en_i) |=> $stable(time_q));

  assert_hour_wr_stops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_field_i == F_HOUR) |=> !run_q);

  assert_tenth_wr_runs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_field_i == F_TENTH) |=> run_q);

  assert_tenth_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run_q && !wr_en_i && time_q.tenth[3:0] != 4'h9)
      |=> time_q.tenth == $past(time_q.tenth) + 8'h01);

endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_50      = 5,
  parameter int DIV_60      = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_i,
  input  logic       mode_50_i,
  input  logic       alarm_sel_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       alarm_o
);

  field_e     field;
  logic [7:0] wdata;
  logic       tick_w, run_w, stepped_w;
  logic       clk_wr, alm_wr;
  tod_t       time_w, alarm_q, snap_q;
  logic       latched_q, evt_q;

  assign field  = field_e'(addr_i);
  assign wdata  = (field == F_HOUR) ? (wr_data_i & HOUR_MASK) : wr_data_i;
  assign clk_wr = wr_en_i & ~alarm_sel_i;
  assign alm_wr = wr_en_i & alarm_sel_i;

  tod_prescaler #(
    .SYNC_STAGES(SYNC_STAGES),
    .DIV_50     (DIV_50),
    .DIV_60     (DIV_60)
  ) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_i   (line_i),
    .mode_50_i(mode_50_i),
    .tick_o   (tick_w)
  );

  tod_time u_time (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_w),
    .wr_en_i   (clk_wr),
    .wr_field_i(field),
    .wr_data_i (wdata),
    .time_o    (time_w),
    .run_o     (run_w),
    .stepped_o (stepped_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= '0;
    end else if (alm_wr) begin
      case (field)
        F_TENTH: alarm_q.tenth  <= wdata;
        F_SEC:   alarm_q.second <= wdata;
        F_MIN:   alarm_q.minute <= wdata;
        default: alarm_q.hour   <= wdata;
      endcase
    end
  end

  // hours read captures, tenths read releases
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q    <= '0;
      latched_q <= 1'b0;
      rd_data_o <= '0;
    end else if (rd_en_i) begin
      rd_data_o <= latched_q ? pick_field(snap_q, field) : pick_field(time_w, field);
      if (!latched_q && field == F_HOUR) begin
        snap_q    <= time_w;
        latched_q <= 1'b1;
      end
      if (field == F_TENTH) latched_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= 1'b0;
    else         evt_q <= wr_en_i | stepped_w;
  end

  assign alarm_o = evt_q & run_w & (time_w == alarm_q);

  assert_snap_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched_q |=> $stable(snap_q));

  assert_alarm_wr_isolated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alm_wr && !tick_w) |=> $stable(time_w));

  assert_alarm_running_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> run_w);

  assert_alarm_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o && !wr_en_i && !tick_w) |=> !alarm_o);

endmodule

// File: tb/tod_clock_tb.sv
module tod_clock_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line = 1'b0;
  logic       mode_50 = 1'b0;
  logic       alarm_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       alarm;

  int total = 0;
  int fails = 0;
  int pcount = 0;
  int alarm_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tod_clock u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .line_i     (line),
    .mode_50_i  (mode_50),
    .alarm_sel_i(alarm_sel),
    .wr_en_i    (wr_en),
    .rd_en_i    (rd_en),
    .addr_i     (addr),
    .wr_data_i  (wr_data),
    .rd_data_o  (rd_data),
    .alarm_o    (alarm)
  );

  always @(negedge clk) if (rst_n && alarm) alarm_cnt++;

  // {wh, wm, ws, wt, eh, em, es, et}: written time, value after one tick
  localparam logic [63:0] VECS [10] = '{
    64'h01_00_00_00_01_00_00_01,
    64'h01_00_00_09_01_00_01_00,
    64'h01_00_59_09_01_01_00_00,
    64'h01_59_59_09_02_00_00_00,
    64'h09_59_59_09_10_00_00_00,
    64'h11_59_59_09_92_00_00_00,
    64'h12_59_59_09_81_00_00_00,
    64'h91_59_59_09_12_00_00_00,
    64'h92_59_59_09_01_00_00_00,
    64'h05_34_27_03_05_34_27_04
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [1:0] a, input logic [7:0] d);
    alarm_sel = sel; addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; alarm_sel = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      line = 1'b1; repeat (3) @(negedge clk);
      line = 1'b0; repeat (3) @(negedge clk);
      pcount++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic one_tick();
    int div;
    div = mode_50 ? 5 : 6;
    pulses(div - (pcount % div));
  endtask

  task automatic set_clock(input logic [7:0] h, m, s, t);
    wr(1'b0, 2'd3, h);
    wr(1'b0, 2'd2, m);
    wr(1'b0, 2'd1, s);
    wr(1'b0, 2'd0, t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int a0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 R10: reset state through the read port
    chk("R9 alarm_o", {7'b0, alarm}, 8'h00);
    rd(2'd3, v); chk("R9 R10 hours", v, 8'h01);
    rd(2'd2, v); chk("R9 R10 minutes", v, 8'h00);
    rd(2'd1, v); chk("R9 R10 seconds", v, 8'h00);
    rd(2'd0, v); chk("R9 R10 tenths", v, 8'h00);
    pulses(6);
    rd(2'd0, v); chk("R9 R5 stopped after reset", v, 8'h00);

    // R2 R3 R6: one tick from each vector
    foreach (VECS[i]) begin
      set_clock(VECS[i][63:56], VECS[i][55:48], VECS[i][47:40], VECS[i][39:32]);
      one_tick();
      rd(2'd3, v); chk($sformatf("R3 R6 vec%0d hours", i), v, VECS[i][31:24]);
      rd(2'd2, v); chk($sformatf("R2 vec%0d minutes", i), v, VECS[i][23:16]);
      rd(2'd1, v); chk($sformatf("R2 vec%0d seconds", i), v, VECS[i][15:8]);
      rd(2'd0, v); chk($sformatf("R2 vec%0d tenths", i), v, VECS[i][7:0]);
    end

    // R5: hours write stops, tenths write restarts (clock at 05:34:27.4)
    wr(1'b0, 2'd3, 8'h05);
    one_tick();
    rd(2'd0, v); chk("R5 stopped ignores tick", v, 8'h04);
    wr(1'b0, 2'd0, 8'h04);
    one_tick();
    rd(2'd0, v); chk("R5 restarted by tenths write", v, 8'h05);

    // R4: snapshot held across a tick, released by tenths read
    rd(2'd3, v); chk("R4 hours capture", v, 8'h05);
    one_tick();
    rd(2'd1, v); chk("R4 seconds from snapshot", v, 8'h27);
    rd(2'd0, v); chk("R4 tenths from snapshot", v, 8'h05);
    rd(2'd0, v); chk("R4 live after release", v, 8'h06);

    // R1: mode change restarts the count; 50 Hz divides by 5
    pulses(3);
    rd(2'd0, v); chk("R1 no tick after 3 of 6", v, 8'h06);
    mode_50 = 1'b1; pcount = 0;
    repeat (4) @(negedge clk);
    pulses(4);
    rd(2'd0, v); chk("R1 no tick after 4 of 5", v, 8'h06);
    pulses(1);
    rd(2'd0, v); chk("R1 tick on 5th pulse", v, 8'h07);
    mode_50 = 1'b0; pcount = 0;
    repeat (4) @(negedge clk);

    // R7 R6: alarm writes leave the clock alone; alarm hour 12 stored unflipped
    a0 = alarm_cnt;
    wr(1'b1, 2'd3, 8'h12);
    wr(1'b1, 2'd2, 8'h00);
    wr(1'b1, 2'd1, 8'h00);
    wr(1'b1, 2'd0, 8'h01);
    rd(2'd3, v); chk("R7 clock hours untouched", v, 8'h05);
    rd(2'd0, v); chk("R7 clock tenths untouched", v, 8'h07);
    chk("R8 no alarm on mismatch", 8'(alarm_cnt - a0), 8'h00);

    // R8 R6: clock written 0x92 stores 0x12; tick reaches alarm 12:00:00.1
    set_clock(8'h92, 8'h00, 8'h00, 8'h00);
    repeat (2) @(negedge clk);
    chk("R8 no alarm before tick", 8'(alarm_cnt - a0), 8'h00);
    one_tick();
    chk("R8 R6 alarm on tick match", 8'(alarm_cnt - a0), 8'h01);

    // R8: write that creates a match while running
    wr(1'b1, 2'd0, 8'h05);
    wr(1'b1, 2'd0, 8'h01);
    repeat (2) @(negedge clk);
    chk("R8 alarm on write match", 8'(alarm_cnt - a0), 8'h02);

    // R8: stopped clock never alarms
    wr(1'b0, 2'd3, 8'h92);
    wr(1'b1, 2'd0, 8'h05);
    wr(1'b1, 2'd0, 8'h01);
    repeat (2) @(negedge clk);
    chk("R8 no alarm while stopped", 8'(alarm_cnt - a0), 8'h02);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule